// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes a serial line made of a bit clock and a data wire, both asynchronous to the system clock, and turns it into 16-bit words. Both wires pass through two-stage synchronizers, and a falling edge of the bit clock marks each bit. While no frame is open the receiver waits for a zero bit. That bit starts a frame and is dropped. After it, each word arrives as 16 data bits, most significant first, followed by one check bit. The frame closes when the bit clock has been quiet for a programmable number of system clocks.

Each complete word is presented for one cycle on a FIFO write port. A bad check bit sets an error flag. A per-frame word counter gives a one-cycle batch event on every fourth word. Three sticky status bits record batch, check-error and end-of-frame events. Each bit is cleared by a write-one-to-clear pulse, and the interrupt line is the OR of the three. When the enable input is low, no frame can start and no word is assembled.

Top module: `framed_serial_rx`

## Requirements
- R1: A falling edge of `sclk_in` samples `sdat_in`. In an open frame the bits are grouped as 16 data bits, most significant first, then one check bit. When the check bit is taken, `push_valid` pulses for one cycle and `push_word` holds the 16 data bits.
- R2: While no frame is open and `rx_en` is high, a falling edge that samples a 0 opens a frame: `frame_active` goes to 1. The start bit is not part of any word.
- R3: An open frame closes (`frame_active` goes to 0) once `eof_limit` system clocks pass with no falling edge. A falling edge restarts this count. When the timeout and a falling edge coincide, the frame closes and the bit is ignored.
- R4: The expected check bit is the inverse of data bit 0 of its word. On a mismatch, status bit `sts[1]` is set and the word is still pushed.
- R5: `batch_evt` pulses together with the 4th, 8th, 12th ... push of a frame. The word count starts from zero in every frame.
- R6: Status bit `sts[2]` is set when an open frame closes on timeout. Serial activity outside an open frame never sets it.
- R7: With `rx_en` low, no frame opens and no word is pushed.
- R8: `sts[0]` is set by each batch event. Every status bit stays set until a 1 arrives on the same bit of `sts_clr`, and the other bits are unaffected. `irq` is the OR of `sts`.
- R9: After reset, `frame_active`, `push_valid`, `batch_evt`, `sts` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| sclk_in | input | 1 | Asynchronous serial bit clock |
| sdat_in | input | 1 | Asynchronous serial data |
| eof_limit | input | TMO_W | Quiet system clocks that end a frame (at least 1) |
| sts_clr | input | 3 | Write-one-to-clear pulses for `sts` |
| push_valid | output | 1 | FIFO write strobe |
| push_word | output | WORD_W | FIFO write data |
| frame_active | output | 1 | High while a frame is open |
| batch_evt | output | 1 | One-cycle pulse on every fourth word of a frame |
| sts | output | 3 | Sticky status: batch, check error, end of frame |
| irq | output | 1 | OR of the status bits |

## Verification
The bench sends frames of one to nine words, so every remainder modulo four is covered. A word counter that failed to wrap, or that carried over from the previous frame, would produce a wrong number of batch events. Word contents are compared bit for bit, which catches a shift register that keeps the start bit or drops the check bit. Some frames carry a deliberately wrong check bit, and the matching frames carry good ones; an inverted comparison would flag good frames and let bad ones through. A burst sent with the enable low must leave the block silent, so an end-of-frame flag outside an open frame, or a start that ignores the enable, is caught. Single-bit clears test that the status bits are independent.

// File: rtl/framed_serial_rx.sv
module framed_serial_rx #(
  parameter int WORD_W = 16,
  parameter int TMO_W  = 8,
  parameter int BATCH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic [TMO_W-1:0]  eof_limit,
  input  logic [2:0]        sts_clr,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_word,
  output logic              frame_active,
  output logic              batch_evt,
  output logic [2:0]        sts,
  output logic              irq
);

  localparam int BC_W = $clog2(WORD_W + 1);
  localparam int WC_W = (BATCH > 1) ? $clog2(BATCH) : 1;

  logic [2:0]        sck_q;
  logic [1:0]        sd_q;
  logic [TMO_W-1:0]  idle_cnt;
  logic [BC_W-1:0]   bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic [WC_W-1:0]   wcnt;
  logic              chk_evt, eof_evt;

  wire fall      = sck_q[2] & ~sck_q[1];
  wire bit_in    = sd_q[1];
  wire zero_det  = rx_en & fall & ~bit_in;
  wire eof_hit   = frame_active & (idle_cnt == eof_limit);
  wire take      = frame_active & ~eof_hit & rx_en & fall;
  wire last      = (bit_cnt == BC_W'(WORD_W));
  wire word_done = take & last;
  wire chk_bad   = (bit_in == shreg[0]);
  wire batch_hit = word_done & (wcnt == WC_W'(BATCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '1;
      sd_q  <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sclk_in};
      sd_q  <= {sd_q[0], sdat_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_active <= 1'b0;
    else if (frame_active) frame_active <= ~eof_hit;
    else frame_active <= zero_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!frame_active || fall) idle_cnt <= '0;
    else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!frame_active || !rx_en) begin
      bit_cnt <= '0;
    end else if (take) begin
      if (last) bit_cnt <= '0;
      else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= {shreg[WORD_W-2:0], bit_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (!frame_active) wcnt <= '0;
    else if (word_done) wcnt <= batch_hit ? '0 : wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_word  <= '0;
      batch_evt  <= 1'b0;
      chk_evt    <= 1'b0;
      eof_evt    <= 1'b0;
      sts        <= '0;
    end else begin
      push_valid <= word_done;
      if (word_done) push_word <= shreg;
      batch_evt  <= batch_hit;
      chk_evt    <= word_done & chk_bad;
      eof_evt    <= eof_hit;
      sts        <= (sts & ~sts_clr) | {eof_evt, chk_evt, batch_evt};
    end
  end

  assign irq = |sts;

  assert_push_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> frame_active);
  assert_batch_with_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    batch_evt |-> push_valid);
  assert_eof_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && eof_hit) |=> !frame_active);
  assert_no_start_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !frame_active) |=> !frame_active);
  assert_eof_only_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> $past(!frame_active) && $past(frame_active, 2));
  assert_clear_batch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr[0] && !batch_evt) |=> !sts[0]);
  assert_irq_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (sts != 3'b000));

endmodule

// File: tb/tb_framed_serial_rx.sv
module tb_framed_serial_rx;
  localparam int H = 4;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1;
  logic sclk_in = 1'b1;
  logic sdat_in = 1'b1;
  logic [7:0] eof_limit = 8'(TMO);
  logic [2:0] sts_clr = 3'b000;
  logic push_valid, frame_active, batch_evt, irq;
  logic [15:0] push_word;
  logic [2:0] sts;

  int tests = 0, fails = 0;
  int pushes = 0, batches = 0;
  logic [15:0] got [0:63];

  always #5 clk = ~clk;

  framed_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .eof_limit(eof_limit), .sts_clr(sts_clr), .push_valid(push_valid),
    .push_word(push_word), .frame_active(frame_active), .batch_evt(batch_evt),
    .sts(sts), .irq(irq)
  );

  always @(negedge clk) begin
    if (push_valid) begin
      got[pushes % 64] = push_word;
      pushes = pushes + 1;
    end
    if (batch_evt) batches = batches + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    sdat_in = b;
    cycles(H);
    sclk_in = 1'b0;
    cycles(H);
    sclk_in = 1'b1;
  endtask

  function automatic logic [15:0] wval(input int f, input int i);
    return 16'hA5C3 ^ 16'(f * 16'h1357) ^ 16'(i * 16'h0F0F);
  endfunction

  task automatic send_frame(input int f, input int n, input int bad_idx, input bit mid_check);
    logic [15:0] w;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      w = wval(f, i);
      for (int b = 15; b >= 0; b--) send_bit(w[b]);
      send_bit(~w[0] ^ (i == bad_idx));
    end
    sdat_in = 1'b1;
    cycles(10);
    if (mid_check) check("R3 frame still open before timeout", frame_active, rx_en);
    cycles(60);
  endtask

  initial begin
    int p0, b0;
    cycles(3);
    check("R9 frame_active after reset", frame_active, 0);
    check("R9 push_valid after reset", push_valid, 0);
    check("R9 batch_evt after reset", batch_evt, 0);
    check("R9 sts after reset", sts, 0);
    check("R9 irq after reset", irq, 0);
    rst_n = 1'b1;
    cycles(5);

    for (int n = 1; n <= 9; n++) begin
      int bad;
      bad = (n % 2 == 1) ? (n - 1) / 2 : -1;
      p0 = pushes; b0 = batches;
      send_frame(n, n, bad, n == 2);
      check("R1 push count", pushes - p0, n);
      for (int i = 0; i < n; i++)
        check("R1 word value", int'(got[(p0 + i) % 64]), int'(wval(n, i)));
      check("R5 batch count", batches - b0, n / 4);
      check("R3 frame closed", frame_active, 0);
      check("R6 eof status", sts[2], 1);
      check("R4 check error status", sts[1], bad >= 0 ? 1 : 0);
      check("R8 batch status", sts[0], n >= 4 ? 1 : 0);
      check("R8 irq", irq, 1);
      sts_clr = 3'b100; cycles(1); sts_clr = 3'b000; cycles(1);
      check("R8 eof cleared alone", sts[2], 0);
      check("R8 check bit kept", sts[1], bad >= 0 ? 1 : 0);
      sts_clr = 3'b011; cycles(1); sts_clr = 3'b000; cycles(1);
      check("R8 all cleared", sts, 0);
      check("R8 irq cleared", irq, 0);
    end

    // start bit opens a frame
    sdat_in = 1'b0; cycles(H); sclk_in = 1'b0; cycles(H);
    check("R2 frame opened by zero bit", frame_active, 1);
    sclk_in = 1'b1; sdat_in = 1'b1;
    cycles(60);
    check("R2 frame closed after lone start", frame_active, 0);
    check("R5 no batch from empty frame", sts[0], 0);
    sts_clr = 3'b111; cycles(1); sts_clr = 3'b000; cycles(1);

    // word count restarts per frame: 3 words then 1 word -> no batch
    b0 = batches;
    send_frame(20, 3, -1, 1'b0);
    send_frame(21, 1, -1, 1'b0);
    check("R5 count cleared between frames", batches - b0, 0);
    sts_clr = 3'b111; cycles(1); sts_clr = 3'b000; cycles(1);

    // disabled receiver
    rx_en = 1'b0;
    p0 = pushes;
    send_frame(30, 4, -1, 1'b1);
    check("R7 no push while disabled", pushes - p0, 0);
    check("R7 no frame while disabled", frame_active, 0);
    check("R6 no eof outside frame", sts, 0);
    rx_en = 1'b1;
    cycles(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule